// File: doc/BRIEF.md
# Copy-Control Line Data Inserter

This block places a 20-bit copy-generation data word into one line of the vertical blanking interval of NTSC video. The timing generator supplies a line-start strobe together with the current line number and field parity. When the line and field match one of the two target lines, and the corresponding field enable is set, the block latches the configured word. It then emits a serial burst: a one-bit-long reference pulse at high level, followed by the 20 data bits, most significant bit first.

The output is a one-bit level plus an active flag. A downstream luma adder turns these into signal amplitude. The last six bits of the word are either taken unchanged from the configuration or replaced by a 6-bit check field that the block computes. No burst is started unless the encoder is in NTSC mode.

Top module: `cgms_line_inserter`

## Requirements
- R1: After reset, out_active and out_level are both 0 and stay 0 until a burst is triggered.
- R2: A burst is triggered only when line_start is 1 and either field_odd=1 with line_num=ODD_LINE (default 20), or field_odd=0 with line_num=EVEN_LINE (default 283).
- R3: en_odd alone permits bursts on the odd-field line and en_even alone permits bursts on the even-field line; a cleared enable blocks its line.
- R4: The first bit period of every burst is a reference pulse: out_level=1 for BIT_CYCLES cycles.
- R5: out_level is 0 in every cycle in which out_active is 0.
- R6: After the reference pulse, cfg_word[19] down to cfg_word[0] are sent in that order, each for BIT_CYCLES cycles. out_active is 1 for exactly 21*BIT_CYCLES consecutive cycles and drops right after the last bit period.
- R7: out_active first reads 1 after the clock edge that comes START_OFFSET edges after the edge that sampled the triggering line_start (START_OFFSET >= 1).
- R8: With crc_auto=0, the last six bits sent are cfg_word[5:0] unchanged.
- R9: With crc_auto=1, the last six bits sent are the CRC of cfg_word[19:6], which are fed MSB first. The CRC uses polynomial x^6+x+1, its register is preset to 6'b111111, and its bit 5 is sent first.
- R10: If std_ntsc is 0 when line_start is sampled, no burst is started.
- R11: cfg_word, crc_auto and the field enables are sampled at the triggering line_start; changing them during a burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | LINE_W | Current line number, valid with line_start |
| field_odd | input | 1 | 1 in the odd field, 0 in the even field |
| std_ntsc | input | 1 | 1 when the encoder is set to NTSC |
| en_odd | input | 1 | Enables insertion on the odd-field line |
| en_even | input | 1 | Enables insertion on the even-field line |
| crc_auto | input | 1 | 1 to compute the 6-bit check field internally |
| cfg_word | input | 20 | Configured data word, bit 19 sent first |
| out_active | output | 1 | High while reference pulse or data bits are sent |
| out_level | output | 1 | Current bit level, 0 when inactive |

## Verification
Counting from the edge that samples line_start, out_active is due after edge START_OFFSET. Each later bit boundary falls every BIT_CYCLES edges, and the flag falls after edge START_OFFSET+21*BIT_CYCLES. For every line it drives, the driver pushes one expected (active, level) pair per cycle, beginning with the falling edge just before the sampling edge. The monitor pops and compares one pair on every falling edge, so each cycle of the burst and of the idle tail is checked at its exact position. Lines that must not fire push an all-idle window of the same length, and this also confirms that nothing starts late.

// File: rtl/cgms_pkg.sv
package cgms_pkg;

  localparam int unsigned WORD_W  = 20;
  localparam int unsigned CHECK_W = 6;
  localparam int unsigned COVER_W = WORD_W - CHECK_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } ser_state_t;

endpackage

// File: rtl/cgms_line_match.sv
module cgms_line_match #(
  parameter int unsigned LINE_W    = 10,
  parameter int unsigned ODD_LINE  = 20,
  parameter int unsigned EVEN_LINE = 283
) (
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic              std_ntsc,
  input  logic              en_odd,
  input  logic              en_even,
  output logic              fire
);

  localparam logic [LINE_W-1:0] ODD_L  = LINE_W'(ODD_LINE);
  localparam logic [LINE_W-1:0] EVEN_L = LINE_W'(EVEN_LINE);

  logic hit_odd;
  logic hit_even;

  always_comb begin
    hit_odd  = field_odd  && (line_num == ODD_L)  && en_odd;
    hit_even = !field_odd && (line_num == EVEN_L) && en_even;
    fire     = line_start && std_ntsc && (hit_odd || hit_even);
  end

endmodule

// File: rtl/cgms_crc_gen.sv
module cgms_crc_gen
  import cgms_pkg::*;
(
  input  logic [COVER_W-1:0] cover_bits,
  output logic [CHECK_W-1:0] crc
);

  logic [CHECK_W-1:0] chain [0:COVER_W];

  assign chain[0] = '1;

  for (genvar i = 0; i < COVER_W; i++) begin : g_step
    logic fb;
    assign fb = cover_bits[COVER_W-1-i] ^ chain[i][CHECK_W-1];
    assign chain[i+1] = {chain[i][CHECK_W-2:0], 1'b0}
                        ^ {{(CHECK_W-2){1'b0}}, fb, fb};
  end

  assign crc = chain[COVER_W];

endmodule

// File: rtl/cgms_serializer.sv
module cgms_serializer
  import cgms_pkg::*;
#(
  parameter int unsigned BIT_CYCLES   = 8,
  parameter int unsigned START_OFFSET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [WORD_W-1:0] word,
  output logic              out_active,
  output logic              out_level
);

  localparam int unsigned SUB_W = $clog2(BIT_CYCLES + 1);
  localparam int unsigned OFF_W = $clog2(START_OFFSET + 1);
  localparam int unsigned IDX_W = $clog2(WORD_W + 2);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BIT_CYCLES - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(START_OFFSET - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W);

  ser_state_t      state_q, state_d;
  logic [OFF_W-1:0] wait_q, wait_d;
  logic [SUB_W-1:0] sub_q,  sub_d;
  logic [IDX_W-1:0] idx_q,  idx_d;
  logic [WORD_W:0]  shreg_q, shreg_d;
  logic             step_en;

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    shreg_d = shreg_q;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          shreg_d = {1'b1, word};
          wait_d  = '0;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wait_q == OFF_LAST) begin
          state_d = ST_SEND;
          sub_d   = '0;
          idx_d   = '0;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      ST_SEND: begin
        if (sub_q == SUB_LAST) begin
          sub_d   = '0;
          shreg_d = {shreg_q[WORD_W-1:0], 1'b0};
          if (idx_q == IDX_LAST) begin
            state_d = ST_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign step_en = (state_q != ST_IDLE) || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      sub_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
    end else if (step_en) begin
      state_q <= state_d;
      wait_q  <= wait_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      shreg_q <= shreg_d;
    end
  end

  assign out_active = (state_q == ST_SEND);
  assign out_level  = out_active && shreg_q[WORD_W];

endmodule

// File: rtl/cgms_line_inserter.sv
module cgms_line_inserter
  import cgms_pkg::*;
#(
  parameter int unsigned LINE_W       = 10,
  parameter int unsigned ODD_LINE     = 20,
  parameter int unsigned EVEN_LINE    = 283,
  parameter int unsigned BIT_CYCLES   = 8,
  parameter int unsigned START_OFFSET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic              std_ntsc,
  input  logic              en_odd,
  input  logic              en_even,
  input  logic              crc_auto,
  input  logic [19:0]       cfg_word,
  output logic              out_active,
  output logic              out_level
);

  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic               fire;
  logic [CHECK_W-1:0] crc_val;
  logic [WORD_W-1:0]  send_word;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  cgms_line_match #(
    .LINE_W   (LINE_W),
    .ODD_LINE (ODD_LINE),
    .EVEN_LINE(EVEN_LINE)
  ) u_match (
    .line_start(line_start),
    .line_num  (line_num),
    .field_odd (field_odd),
    .std_ntsc  (std_ntsc),
    .en_odd    (en_odd),
    .en_even   (en_even),
    .fire      (fire)
  );

  cgms_crc_gen u_crc (
    .cover_bits(cfg_word[WORD_W-1:CHECK_W]),
    .crc       (crc_val)
  );

  always_comb begin
    if (crc_auto) send_word = {cfg_word[WORD_W-1:CHECK_W], crc_val};
    else          send_word = cfg_word;
  end

  cgms_serializer #(
    .BIT_CYCLES  (BIT_CYCLES),
    .START_OFFSET(START_OFFSET)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fire      (fire),
    .word      (send_word),
    .out_active(out_active),
    .out_level (out_level)
  );

endmodule

// File: rtl/cgms_line_inserter_chk.sv
module cgms_line_inserter_chk #(
  parameter int unsigned BIT_CYCLES   = 8,
  parameter int unsigned START_OFFSET = 16
) (
  input logic clk,
  input logic rst_n,
  input logic line_start,
  input logic out_active,
  input logic out_level
);

  localparam int unsigned TOTAL = 21 * BIT_CYCLES;
  localparam int unsigned RUN_W = $clog2(TOTAL + 2);
  localparam int unsigned SIN_W = $clog2(START_OFFSET + 2);
  localparam logic [SIN_W-1:0] SIN_MAX = '1;

  logic [RUN_W-1:0] run_q;
  logic [SIN_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      since_q <= SIN_MAX;
    end else begin
      run_q <= out_active ? run_q + 1'b1 : '0;
      if (line_start)             since_q <= '0;
      else if (since_q != SIN_MAX) since_q <= since_q + 1'b1;
    end
  end

  p_level_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_active |-> !out_level);

  p_ref_pulse_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_active) |-> out_level);

  p_burst_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_active) |-> (run_q == RUN_W'(TOTAL)));

  p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_active && $past(out_active) && ((run_q % RUN_W'(BIT_CYCLES)) != 0))
      |-> $stable(out_level));

  p_start_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_active) |-> (since_q == SIN_W'(START_OFFSET)));

endmodule

bind cgms_line_inserter cgms_line_inserter_chk #(
  .BIT_CYCLES  (BIT_CYCLES),
  .START_OFFSET(START_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_start(line_start),
  .out_active(out_active),
  .out_level (out_level)
);

// File: tb/sim_cgms_line_inserter.sv
module sim_cgms_line_inserter;

  localparam int CLK_PERIOD = 10;
  localparam int BC   = 8;
  localparam int OFF  = 16;
  localparam int TOT  = 21 * BC;
  localparam int WIN  = 1 + OFF + TOT + 4;

  typedef struct {
    logic  act;
    logic  lvl;
    int    idx;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_start;
  logic [9:0]  line_num;
  logic        field_odd, std_ntsc, en_odd, en_even, crc_auto;
  logic [19:0] cfg_word;
  logic        out_active, out_level;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cgms_line_inserter #(
    .LINE_W(10), .ODD_LINE(20), .EVEN_LINE(283),
    .BIT_CYCLES(BC), .START_OFFSET(OFF)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .field_odd(field_odd), .std_ntsc(std_ntsc), .en_odd(en_odd),
    .en_even(en_even), .crc_auto(crc_auto), .cfg_word(cfg_word),
    .out_active(out_active), .out_level(out_level)
  );

  // check field per R9: divide by x^6+x+1, register preset to ones
  function automatic logic [5:0] ref_crc(input logic [13:0] d);
    logic [5:0] r = 6'h3F;
    for (int k = 13; k >= 0; k--) begin
      logic top = r[5];
      r = r << 1;
      if (top ^ d[k]) r = r ^ 6'b000011;
    end
    return r;
  endfunction

  // monitor: one expected pair per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (out_active !== e.act || out_level !== e.lvl) begin
        fails++;
        $display("FAIL %s cycle %0d: active/level got %b/%b expected %b/%b",
                 e.tag, e.idx, out_active, out_level, e.act, e.lvl);
      end
    end
  end

  task automatic run_line(input logic ntsc, input logic odd, input logic [9:0] ln,
                          input logic eo, input logic ee, input logic ca,
                          input logic [19:0] w, input bit mid_write,
                          input string tag);
    logic [19:0] sent;
    bit fires;
    fires = ntsc && ((odd && ln == 10'd20 && eo) || (!odd && ln == 10'd283 && ee));
    sent  = ca ? {w[19:6], ref_crc(w[19:6])} : w;
    @(posedge clk); #1;
    std_ntsc = ntsc; field_odd = odd; line_num = ln;
    en_odd = eo; en_even = ee; crc_auto = ca; cfg_word = w;
    line_start = 1'b1;
    for (int j = -1; j < WIN - 1; j++) begin
      exp_t e;
      e.idx = j; e.tag = tag; e.act = 1'b0; e.lvl = 1'b0;
      if (fires && j >= OFF && j < OFF + TOT) begin
        int b;
        b = (j - OFF) / BC;
        e.act = 1'b1;
        e.lvl = (b == 0) ? 1'b1 : sent[20 - b];
      end
      q.push_back(e);
    end
    @(posedge clk); #1;
    line_start = 1'b0;
    if (mid_write) begin // R11: rewrite every sampled input during the burst
      cfg_word = ~w; crc_auto = ~ca; en_odd = ~eo; en_even = ~ee;
    end
    wait (q.size() == 0);
  endtask

  initial begin
    rst_n = 1'b0; line_start = 1'b0; line_num = '0; field_odd = 1'b0;
    std_ntsc = 1'b1; en_odd = 1'b0; en_even = 1'b0; crc_auto = 1'b0;
    cfg_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_active !== 1'b0 || out_level !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: active/level got %b/%b expected 0/0",
               out_active, out_level);
    end
    // R2 R4 R6 R7 R9: odd line, computed check field
    run_line(1, 1, 10'd20,  1, 0, 1, 20'hA5C3F, 0, "R2_R9_odd_crc");
    // R2 R3 R8: even line, stored check field
    run_line(1, 0, 10'd283, 0, 1, 0, 20'h3C96A, 0, "R8_even_pass");
    // R3: disabled field enable blocks each line
    run_line(1, 1, 10'd20,  0, 1, 0, 20'hFFFFF, 0, "R3_odd_off");
    run_line(1, 0, 10'd283, 1, 0, 0, 20'hFFFFF, 0, "R3_even_off");
    // R2: wrong line or wrong field parity
    run_line(1, 1, 10'd21,  1, 1, 0, 20'hFFFFF, 0, "R2_line21");
    run_line(1, 1, 10'd283, 1, 1, 0, 20'hFFFFF, 0, "R2_283_odd");
    run_line(1, 0, 10'd20,  1, 1, 0, 20'hFFFFF, 0, "R2_20_even");
    // R10: not NTSC
    run_line(0, 1, 10'd20,  1, 1, 1, 20'hFFFFF, 0, "R10_odd");
    run_line(0, 0, 10'd283, 1, 1, 0, 20'hFFFFF, 0, "R10_even");
    // R11: mid-burst writes ignored
    run_line(1, 0, 10'd283, 0, 1, 1, 20'h12345, 1, "R11_midwrite");
    run_line(1, 1, 10'd20,  1, 0, 0, 20'h80001, 1, "R11_midwrite2");
    // R9 corner words, R5 all-zero data
    run_line(1, 1, 10'd20,  1, 1, 1, 20'h00000, 0, "R9_zero");
    run_line(1, 0, 10'd283, 1, 1, 1, 20'hFFFFF, 0, "R9_ones");
    run_line(1, 1, 10'd20,  1, 1, 0, 20'h00000, 0, "R5_R8_zero");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule